// File: doc/BRIEF.md
# Byte-Lane Synchronous Static Memory Port

A single-port synchronous memory that stores words made of byte lanes, each lane being eight data bits plus one parity bit (two lanes, 18 bits per word, by default). Address, chip selects and write controls are captured on the rising clock edge. A read is flow-through: the addressed word reaches the output during the cycle that follows the capturing edge, with no extra output register. The depth is set by an address-width parameter and is kept small for simulation.

A write can update any set of lanes. Each lane has its own active-low enable that covers the lane's data bits and its parity bit, and an active-low global write forces every lane to be written. The port is selected only when three chip selects of mixed polarity agree. The shared data bus is modelled as a pad-side pair: the word to drive and a drive-enable. An asynchronous output enable gates the drive. An asynchronous snooze input turns the drive off at once and blocks writes while it is held, so the stored contents stay intact.

Top module: `sram_bw_port`

## Requirements
- R1: A word is 18 bits. Lane a is bus bits [8:0] (data [7:0], parity [8]) and lane b is bits [17:9] (data [16:9], parity [17]). With global write high and only lane_we_n_i[0] low, a selected write updates lane a alone and leaves lane b unchanged.
- R2: With global write high and only lane_we_n_i[1] low, a selected write updates lane b, including its parity bit, and leaves lane a unchanged.
- R3: With gwe_n_i low, a selected write updates both lanes whatever the values on lane_we_n_i.
- R4: The port is selected at an edge only when sel_n_i is 0, sel_hi_i is 1 and sel2_n_i is 0. An edge without selection writes nothing and leaves dq_oe_o low for the next cycle.
- R5: After a selected edge with no write enable active, dq_o carries the stored word at that edge's address within the same cycle, and dq_oe_o is high while oe_n_i is low and snooze_i is low.
- R6: oe_n_i acts without the clock: raising it drops dq_oe_o at once, and lowering it again restores the drive within the same cycle.
- R7: While snooze_i is high, dq_oe_o is low at once, and writes captured at edges where snooze_i is high are ignored. The stored words are unchanged once snooze_i is released.
- R8: In the cycle after a selected write edge, dq_oe_o is low even with oe_n_i low, so the bus stays free for write data.
- R9: While rst_n is low and after its release until a selected read edge, dq_oe_o is low.
- R10: A selected edge with gwe_n_i high and every lane_we_n_i bit high is a read and changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all captures on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr_i | input | ADDR_W (6) | Word address |
| sel_n_i | input | 1 | Primary chip select, active low |
| sel_hi_i | input | 1 | Second chip select, active high |
| sel2_n_i | input | 1 | Third chip select, active low |
| gwe_n_i | input | 1 | Global write, active low; writes all lanes |
| lane_we_n_i | input | LANES (2) | Per-lane write enables, active low; bit 0 is lane a |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| snooze_i | input | 1 | Asynchronous snooze; blocks drive and writes |
| dq_i | input | 18 | Write data seen on the shared bus |
| dq_o | output | 18 | Read word to drive onto the shared bus |
| dq_oe_o | output | 1 | Drive enable for the shared bus |

## Verification
On every clock the checker confirms that the drive enable is off whenever the output enable is raised or snooze is held, after every unselected edge and after every write edge, and that it is on after a selected read with the output enable low, and it confirms that the drive stays off in reset. Whether the right lanes were written, whether parity bits move with their lanes, whether the global write overrides the lane enables, and whether writes during snooze left memory intact can only be shown by the bench, which holds a word-level model and compares read-back data. The asynchronous reaction to the output enable and snooze between clock edges is also probed by the bench directly.

// File: rtl/sram_bw_pkg.sv
`timescale 1ns/1ps
package sram_bw_pkg;

   // What the captured edge asked of the port.
   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_READ  = 2'd1,
      CYC_WRITE = 2'd2
   } cyc_kind_e;

   // Lane set for a write: global write covers all lanes.
   function automatic logic [7:0] lane_set(input logic gwe_n, input logic [7:0] we_n,
                                           input int unsigned lanes);
      logic [7:0] m;
      for (int i = 0; i < 8; i++)
         m[i] = (i < lanes) ? (~gwe_n | ~we_n[i]) : 1'b0;
      return m;
   endfunction

endpackage

// File: rtl/sram_bw_ctrl.sv
`timescale 1ns/1ps
module sram_bw_ctrl
   import sram_bw_pkg::*;
#(
   parameter int unsigned LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_n,
   input  logic             sel_hi,
   input  logic             sel2_n,
   input  logic             gwe_n,
   input  logic [LANES-1:0] lane_we_n,
   input  logic             snooze,
   output logic [LANES-1:0] lane_wr,
   output cyc_kind_e        kind_q
);

   logic       selected;
   logic       any_we;
   logic [7:0] we_ext;
   logic [7:0] mask;
   cyc_kind_e  kind_d;

   always_comb begin
      we_ext = '1;
      we_ext[LANES-1:0] = lane_we_n;
   end

   assign selected = ~sel_n & sel_hi & ~sel2_n;
   assign mask     = lane_set(gwe_n, we_ext, LANES);
   assign any_we   = |mask[LANES-1:0];

   // Writes only land when selected and not snoozing.
   assign lane_wr = (selected && !snooze) ? mask[LANES-1:0] : '0;

   always_comb begin
      if (!selected)   kind_d = CYC_IDLE;
      else if (any_we) kind_d = CYC_WRITE;
      else             kind_d = CYC_READ;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) kind_q <= CYC_IDLE;
      else        kind_q <= kind_d;
   end

endmodule

// File: rtl/sram_bw_lane.sv
`timescale 1ns/1ps
module sram_bw_lane #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned LANE_W = 9
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [LANE_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [LANE_W-1:0] rd_data
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) cells[wr_addr] <= wr_data;
   end

   // Flow-through: no output register.
   assign rd_data = cells[rd_addr];

endmodule

// File: rtl/sram_bw_drive.sv
`timescale 1ns/1ps
module sram_bw_drive
   import sram_bw_pkg::*;
#(
   parameter int unsigned WORD_W = 18
) (
   input  cyc_kind_e         kind_q,
   input  logic              oe_n,
   input  logic              snooze,
   input  logic [WORD_W-1:0] rd_word,
   output logic [WORD_W-1:0] dq_o,
   output logic              dq_oe
);

   // Output enable and snooze are level-acting, not sampled.
   assign dq_oe = (kind_q == CYC_READ) && !oe_n && !snooze;
   assign dq_o  = rd_word;

endmodule

// File: rtl/sram_bw_port.sv
`timescale 1ns/1ps
module sram_bw_port
   import sram_bw_pkg::*;
#(
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned LANES       = 2,
   parameter int unsigned LANE_DATA_W = 8,
   parameter bit          PARITY_EN   = 1'b1,
   localparam int unsigned LANE_W     = LANE_DATA_W + (PARITY_EN ? 1 : 0),
   localparam int unsigned WORD_W     = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              sel_n_i,
   input  logic              sel_hi_i,
   input  logic              sel2_n_i,
   input  logic              gwe_n_i,
   input  logic [LANES-1:0]  lane_we_n_i,
   input  logic              oe_n_i,
   input  logic              snooze_i,
   input  logic [WORD_W-1:0] dq_i,
   output logic [WORD_W-1:0] dq_o,
   output logic              dq_oe_o
);

   generate
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
         $error("sram_bw_port: ADDR_W must be 1..10");
      end
      if (LANES < 1 || LANES > 8) begin : g_bad_lanes
         $error("sram_bw_port: LANES must be 1..8");
      end
      if (LANE_DATA_W < 1 || LANE_DATA_W > 64) begin : g_bad_lane_w
         $error("sram_bw_port: LANE_DATA_W must be 1..64");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_q;
   logic [LANES-1:0]  lane_wr;
   cyc_kind_e         kind_q;
   logic [WORD_W-1:0] rd_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr_q <= '0;
      else        addr_q <= addr_i;
   end

   sram_bw_ctrl #(.LANES(LANES)) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_n     (sel_n_i),
      .sel_hi    (sel_hi_i),
      .sel2_n    (sel2_n_i),
      .gwe_n     (gwe_n_i),
      .lane_we_n (lane_we_n_i),
      .snooze    (snooze_i),
      .lane_wr   (lane_wr),
      .kind_q    (kind_q)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      sram_bw_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) bank_i (
         .clk     (clk),
         .wr_en   (lane_wr[g]),
         .wr_addr (addr_i),
         .wr_data (dq_i[g*LANE_W +: LANE_W]),
         .rd_addr (addr_q),
         .rd_data (rd_word[g*LANE_W +: LANE_W])
      );
   end

   sram_bw_drive #(.WORD_W(WORD_W)) drive_i (
      .kind_q  (kind_q),
      .oe_n    (oe_n_i),
      .snooze  (snooze_i),
      .rd_word (rd_word),
      .dq_o    (dq_o),
      .dq_oe   (dq_oe_o)
   );

endmodule

// File: rtl/sram_bw_port_chk.sv
`timescale 1ns/1ps
module sram_bw_port_chk #(
   parameter int unsigned LANES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sel_n_i,
   input logic             sel_hi_i,
   input logic             sel2_n_i,
   input logic             gwe_n_i,
   input logic [LANES-1:0] lane_we_n_i,
   input logic             oe_n_i,
   input logic             snooze_i,
   input logic             dq_oe_o
);

   logic picked;
   logic wants_wr;
   assign picked   = !sel_n_i && sel_hi_i && !sel2_n_i;
   assign wants_wr = !gwe_n_i || !(&lane_we_n_i);

   // R6
   a_r6_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n_i |-> !dq_oe_o);

   // R7
   a_r7_snooze_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      snooze_i |-> !dq_oe_o);

   // R4
   a_r4_unselected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!picked)) |-> !dq_oe_o);

   // R8
   a_r8_write_release: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(picked && wants_wr)) |-> !dq_oe_o);

   // R5 and R10
   a_r5_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(picked && !wants_wr) && !oe_n_i && !snooze_i) |-> dq_oe_o);

   // R9
   always_comb begin
      if (!rst_n) begin
         a_r9_reset_quiet: assert (!dq_oe_o);
      end
   end

endmodule

bind sram_bw_port sram_bw_port_chk #(.LANES(LANES)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .sel_n_i     (sel_n_i),
   .sel_hi_i    (sel_hi_i),
   .sel2_n_i    (sel2_n_i),
   .gwe_n_i     (gwe_n_i),
   .lane_we_n_i (lane_we_n_i),
   .oe_n_i      (oe_n_i),
   .snooze_i    (snooze_i),
   .dq_oe_o     (dq_oe_o)
);

// File: tb/sram_bw_port_tb_top.sv
`timescale 1ns/1ps
module sram_bw_port_tb_top;

   localparam int unsigned AW    = 6;
   localparam int unsigned DEPTH = 1 << AW;
   localparam int unsigned WW    = 18;

   typedef struct {
      logic          exp_oe;
      logic [WW-1:0] exp_data;
      string         req;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          sel_n = 1'b1, sel_hi = 1'b0, sel2_n = 1'b1;
   logic          gwe_n = 1'b1;
   logic [1:0]    we_n = 2'b11;
   logic          oe_n = 1'b0, snooze = 1'b0;
   logic [WW-1:0] din = '0;
   logic [WW-1:0] dq_o;
   logic          dq_oe;

   int total = 0;
   int bad   = 0;
   item_t sb[$];
   logic [WW-1:0] model [DEPTH];

   always #2 clk = ~clk;

   sram_bw_port #(.ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr_i(addr),
      .sel_n_i(sel_n), .sel_hi_i(sel_hi), .sel2_n_i(sel2_n),
      .gwe_n_i(gwe_n), .lane_we_n_i(we_n),
      .oe_n_i(oe_n), .snooze_i(snooze),
      .dq_i(din), .dq_o(dq_o), .dq_oe_o(dq_oe)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Driver: one captured edge per call, expectation pushed to the scoreboard.
   task automatic cyc(input logic s_n, input logic s_hi, input logic s2_n,
                      input logic g_n, input logic [1:0] w_n,
                      input logic [AW-1:0] a, input logic [WW-1:0] d,
                      input logic o_n, input logic z, input string req);
      logic sel, wr;
      item_t it;
      @(negedge clk);
      sel_n = s_n; sel_hi = s_hi; sel2_n = s2_n;
      gwe_n = g_n; we_n = w_n; addr = a; din = d; oe_n = o_n; snooze = z;
      @(posedge clk);
      sel = !s_n && s_hi && !s2_n;
      wr  = sel && (!g_n || !(&w_n));
      if (wr && !z) begin
         if (!g_n || !w_n[0]) model[a][8:0]  = d[8:0];
         if (!g_n || !w_n[1]) model[a][17:9] = d[17:9];
      end
      it.exp_oe   = sel && !wr && !o_n && !z;
      it.exp_data = model[a];
      it.req      = req;
      sb.push_back(it);
   endtask

   task automatic wr_all(input logic [AW-1:0] a, input logic [WW-1:0] d, input string req);
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 2'b11, a, d, 1'b0, 1'b0, req);
   endtask
   task automatic wr_lane(input logic [1:0] w_n, input logic [AW-1:0] a,
                          input logic [WW-1:0] d, input string req);
      cyc(1'b0, 1'b1, 1'b0, 1'b1, w_n, a, d, 1'b0, 1'b0, req);
   endtask
   task automatic rd(input logic [AW-1:0] a, input string req);
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 2'b11, a, '0, 1'b0, 1'b0, req);
   endtask

   // Monitor: compares one time unit after each edge, inside the same cycle.
   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         chk(dq_oe === it.exp_oe, {it.req, " drive"}, {31'd0, dq_oe}, {31'd0, it.exp_oe});
         if (it.exp_oe)
            chk(dq_o === it.exp_data, {it.req, " data"}, {14'd0, dq_o}, {14'd0, it.exp_data});
      end
   end

   initial begin
      #(4 * 60000);
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R9: reset state, even with output enable low
      repeat (3) @(posedge clk);
      #1 chk(dq_oe === 1'b0, "R9 in reset", {31'd0, dq_oe}, 32'd0);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;
      chk(dq_oe === 1'b0, "R9 after release", {31'd0, dq_oe}, 32'd0);

      // R3: global write, with and without lane enables
      wr_all(6'd3, 18'h2A5A5, "R3 gw");
      rd(6'd3, "R5 read after gw");
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 2'b10, 6'd3, 18'h15A5A, 1'b0, 1'b0, "R3 gw over lane");
      rd(6'd3, "R3 readback");
      // R1: lane a only, parity bit 8 included
      wr_lane(2'b10, 6'd3, 18'h3FFFF, "R1 lane a");
      rd(6'd3, "R1 readback");
      // R2: lane b only, parity bit 17 included
      wr_lane(2'b01, 6'd3, 18'h20000, "R2 lane b");
      rd(6'd3, "R2 readback");
      // both lane enables, global high
      wr_lane(2'b00, 6'd4, 18'h1C3C3, "R1 R2 both lanes");
      rd(6'd4, "R1 R2 readback");

      // R4: each select in the wrong state blocks write and drive
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 6'd4, 18'h0, 1'b0, 1'b0, "R4 sel_n high");
      cyc(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 6'd4, 18'h0, 1'b0, 1'b0, "R4 sel_hi low");
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 6'd4, 18'h0, 1'b0, 1'b0, "R4 sel2_n high");
      cyc(1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 6'd4, 18'h0, 1'b0, 1'b0, "R4 unselected read");
      rd(6'd4, "R4 contents kept");

      // R10: read changes nothing
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 6'd4, 18'h3FFFF, 1'b0, 1'b0, "R10 read w/ data");
      rd(6'd4, "R10 contents kept");

      // R8: write with oe low never drives (drive checked on each write item)
      wr_all(6'd5, 18'h00155, "R8 write release");
      rd(6'd5, "R8 readback");

      // R7: snooze blocks writes and drive; contents preserved
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 6'd5, 18'h3FFFF, 1'b0, 1'b1, "R7 snooze write");
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 6'd5, 18'h0, 1'b0, 1'b1, "R7 snooze read");
      rd(6'd5, "R7 preserved");

      // R6 and R7: asynchronous gating within a read cycle
      rd(6'd4, "R6 setup");
      @(negedge clk); #0.5;
      chk(dq_oe === 1'b1, "R6 drive before", {31'd0, dq_oe}, 32'd1);
      oe_n = 1'b1; #0.2;
      chk(dq_oe === 1'b0, "R6 oe raised", {31'd0, dq_oe}, 32'd0);
      oe_n = 1'b0; #0.2;
      chk(dq_oe === 1'b1 && dq_o === model[4], "R6 oe lowered",
          {14'd0, dq_o}, {14'd0, model[4]});
      snooze = 1'b1; #0.2;
      chk(dq_oe === 1'b0, "R7 async snooze", {31'd0, dq_oe}, 32'd0);
      snooze = 1'b0; #0.2;
      chk(dq_oe === 1'b1, "R7 snooze released", {31'd0, dq_oe}, 32'd1);

      // R5: fill and read back a spread of addresses
      for (int a = 0; a < DEPTH; a++)
         wr_all(AW'(a), 18'((a * 18'h0A3B7) ^ 18'h24924), "R5 fill");
      for (int a = 0; a < DEPTH; a += 5)
         rd(AW'(a), "R5 sweep");
      rd(6'd63, "R5 top address");
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 6'd7, 18'h0, 1'b1, 1'b0, "R6 read oe high");

      repeat (3) @(posedge clk);
      #2;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule